// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits between a microcontroller's byte-wide special-function-register write port and an embedded flash macro. Firmware loads a page field and, when it wants to wipe the whole array, sets a one-shot mass-erase enable bit. It then writes a key byte to the command register. The sequencer checks that the key matches one of two fixed patterns and that the preconditions for that erase are met. Only then does it raise an erase request, together with a page index and a mass flag, towards the flash macro, and it holds that request until the macro acknowledges.

Each erase uses up its preconditions. A finished erase leaves the sequencer busy until firmware closes the cycle by writing zero to the command register. The block also holds a program-write-enable bit. While that bit is set, data-move writes from the core go to flash program space instead of data RAM. Writes to that bit are blocked while the core's global interrupt enable is high.

Register map (2-bit address): 0 = command (reads 0x00), 1 = control (bit 0 program-write-enable, bit 1 mass-erase enable), 2 = page field (bits 5:0), 3 = status (bit 0 busy, bit 1 waiting for close, read only).

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, erase_req_o, prog_we_o and busy are 0, and the control, page and status registers read 0x00.
- R2: Writing 0x55 to the command register while idle starts a page erase, but only if the page field register has been written since the last erase started. From the next cycle, erase_req_o is 1, erase_mass_o is 0 and erase_page_o is {bank_i, page field}.
- R3: Writing 0xAA to the command register while idle starts a mass erase, but only if the mass-erase enable bit (control bit 1) is 1 and dbg_en_i is 1. From the next cycle, erase_req_o is 1, erase_mass_o is 1 and erase_page_o is 0.
- R4: Writing any nonzero command value other than 0x55 or 0xAA starts nothing, and the status register stays 0x00.
- R5: Writing 0x55 without a page field write since the last erase start is ignored.
- R6: Writing 0xAA is ignored when the mass-erase enable bit is 0 or when dbg_en_i is 0.
- R7: Starting any erase clears the page-written mark and the mass-erase enable bit, so both must be written again before the next erase.
- R8: erase_req_o, erase_mass_o and erase_page_o stay stable until erase_ack_i is seen high. erase_req_o falls in the cycle after that.
- R9: After the acknowledge, status reads 0x03 until firmware writes 0x00 to the command register. A zero write made during the request closes the cycle as soon as the acknowledge arrives. Nonzero command writes are ignored while busy.
- R10: When program-write-enable is 1, mov_we_i drives prog_we_o and xram_we_o stays 0. When it is 0, mov_we_i drives xram_we_o and prog_we_o stays 0.
- R11: A control write while gie_i is 1 leaves program-write-enable unchanged, but still updates the mass-erase enable bit.
- R12: Asserting reset during a request drops erase_req_o at once and returns status to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 2 | Register address |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read data for sfr_addr_i |
| gie_i | input | 1 | Core global interrupt enable |
| dbg_en_i | input | 1 | Debug port enabled |
| bank_i | input | 1 | Bank bits forming the upper page index |
| mov_we_i | input | 1 | Data-move write strobe from the core |
| prog_we_o | output | 1 | Write strobe to program flash space |
| xram_we_o | output | 1 | Write strobe to data RAM |
| erase_req_o | output | 1 | Erase request to flash macro |
| erase_mass_o | output | 1 | Request is a mass erase |
| erase_page_o | output | 7 | Page index to erase |
| erase_ack_i | input | 1 | Flash macro done |

## Verification
The erase command is exercised with four kinds of key. The two valid keys, each with its preconditions met, tell the page path apart from the mass path through the mass flag and the page index. Valid keys with a precondition missing or already used up (no page write, enable bit clear, debug port off) show that the gating blocks them. A stray nonzero key shows that only the exact patterns decode. Valid keys sent while busy, and zero writes sent before and after the acknowledge, separate the close handling from the start handling. A scoreboard matches every erase request the macro sees against the queue of requests the bench expects.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] REG_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] REG_PAGE = 2'd2;
  localparam logic [ADDR_W-1:0] REG_STAT = 2'd3;
  localparam logic [DATA_W-1:0] KEY_PAGE = 8'h55;
  localparam logic [DATA_W-1:0] KEY_MASS = 8'hAA;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_HOLD = 2'd2
  } erase_state_e;
endpackage

// File: rtl/flash_erase_regs.sv
module flash_erase_regs #(
  parameter int PG_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctrl_we_i,
  input  logic [1:0]      ctrl_wdata_i,
  input  logic            page_we_i,
  input  logic [PG_W-1:0] page_wdata_i,
  input  logic            gie_i,
  input  logic            consume_i,
  output logic            pwe_o,
  output logic            meen_o,
  output logic [PG_W-1:0] page_field_o,
  output logic            page_armed_o
);
  logic            pwe_q, meen_q, armed_q;
  logic [PG_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwe_q <= 1'b0;
    end else if (ctrl_we_i && !gie_i) begin
      pwe_q <= ctrl_wdata_i[0];
    end
  end

  // one-shot enables: a start consumes them, a fresh write re-arms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meen_q  <= 1'b0;
      armed_q <= 1'b0;
      page_q  <= '0;
    end else begin
      if (consume_i)      meen_q <= 1'b0;
      else if (ctrl_we_i) meen_q <= ctrl_wdata_i[1];
      if (consume_i)      armed_q <= 1'b0;
      else if (page_we_i) armed_q <= 1'b1;
      if (page_we_i)      page_q <= page_wdata_i;
    end
  end

  assign pwe_o        = pwe_q;
  assign meen_o       = meen_q;
  assign page_field_o = page_q;
  assign page_armed_o = armed_q;

  AST_PWE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && gie_i) |=> $stable(pwe_q)) else $error("pwe changed under gie"); // R11

  AST_ARM_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |=> (!armed_q && !meen_q)) else $error("enable survived start"); // R7
endmodule

// File: rtl/flash_erase_fsm.sv
module flash_erase_fsm
  import flash_erase_pkg::*;
#(
  parameter int PG_W   = 6,
  parameter int BANK_W = 1,
  localparam int PAGE_W = PG_W + BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              page_armed_i,
  input  logic              meen_i,
  input  logic              dbg_en_i,
  input  logic [PG_W-1:0]   page_field_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              mass_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              consume_o,
  output logic              busy_o,
  output logic              hold_o
);
  erase_state_e      state_q, state_d;
  logic              mass_q, close_q, close_d;
  logic [PAGE_W-1:0] page_q, page_idx;
  logic              start_page, start_mass, zero_wr;

  generate
    if (BANK_W > 0) begin : g_bank
      assign page_idx = {bank_i, page_field_i};
    end else begin : g_nobank
      assign page_idx = page_field_i;
    end
  endgenerate

  assign zero_wr    = cmd_we_i && (cmd_data_i == '0);
  assign start_page = (state_q == ST_IDLE) && cmd_we_i && (cmd_data_i == KEY_PAGE) && page_armed_i;
  assign start_mass = (state_q == ST_IDLE) && cmd_we_i && (cmd_data_i == KEY_MASS) && meen_i && dbg_en_i;
  assign consume_o  = start_page || start_mass;

  always_comb begin
    state_d = state_q;
    close_d = close_q;
    unique case (state_q)
      ST_IDLE: begin
        close_d = 1'b0;
        if (consume_o) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (zero_wr) close_d = 1'b1;
        if (ack_i) state_d = (close_q || zero_wr) ? ST_IDLE : ST_HOLD;
      end
      ST_HOLD: if (zero_wr) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      close_q <= 1'b0;
      mass_q  <= 1'b0;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      close_q <= close_d;
      if (consume_o) begin
        mass_q <= start_mass;
        page_q <= start_mass ? '0 : page_idx;
      end
    end
  end

  assign req_o  = (state_q == ST_REQ);
  assign mass_o = mass_q;
  assign page_o = page_q;
  assign busy_o = (state_q != ST_IDLE);
  assign hold_o = (state_q == ST_HOLD);

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(page_o) && $stable(mass_o))) else $error("req unstable"); // R8

  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> !req_o) else $error("req held past ack"); // R8

  AST_HOLD_ENDS_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !zero_wr) |=> hold_o) else $error("hold left without close"); // R9
endmodule

// File: rtl/flash_move_route.sv
module flash_move_route (
  input  logic mov_we_i,
  input  logic pwe_i,
  output logic prog_we_o,
  output logic xram_we_o
);
  assign prog_we_o = mov_we_i && pwe_i;
  assign xram_we_o = mov_we_i && !pwe_i;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int PG_W   = 6,
  parameter int BANK_W = 1,
  localparam int PAGE_W = PG_W + BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sfr_we_i,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic [DATA_W-1:0] sfr_wdata_i,
  output logic [DATA_W-1:0] sfr_rdata_o,
  input  logic              gie_i,
  input  logic              dbg_en_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              mov_we_i,
  output logic              prog_we_o,
  output logic              xram_we_o,
  output logic              erase_req_o,
  output logic              erase_mass_o,
  output logic [PAGE_W-1:0] erase_page_o,
  input  logic              erase_ack_i
);
  logic            pwe, meen, armed, consume, busy, hold;
  logic [PG_W-1:0] page_field;

  flash_erase_regs #(.PG_W(PG_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (sfr_we_i && (sfr_addr_i == REG_CTRL)),
    .ctrl_wdata_i (sfr_wdata_i[1:0]),
    .page_we_i    (sfr_we_i && (sfr_addr_i == REG_PAGE)),
    .page_wdata_i (sfr_wdata_i[PG_W-1:0]),
    .gie_i        (gie_i),
    .consume_i    (consume),
    .pwe_o        (pwe),
    .meen_o       (meen),
    .page_field_o (page_field),
    .page_armed_o (armed)
  );

  flash_erase_fsm #(.PG_W(PG_W), .BANK_W(BANK_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_we_i     (sfr_we_i && (sfr_addr_i == REG_CMD)),
    .cmd_data_i   (sfr_wdata_i),
    .page_armed_i (armed),
    .meen_i       (meen),
    .dbg_en_i     (dbg_en_i),
    .page_field_i (page_field),
    .bank_i       (bank_i),
    .ack_i        (erase_ack_i),
    .req_o        (erase_req_o),
    .mass_o       (erase_mass_o),
    .page_o       (erase_page_o),
    .consume_o    (consume),
    .busy_o       (busy),
    .hold_o       (hold)
  );

  flash_move_route u_route (
    .mov_we_i  (mov_we_i),
    .pwe_i     (pwe),
    .prog_we_o (prog_we_o),
    .xram_we_o (xram_we_o)
  );

  always_comb begin
    sfr_rdata_o = '0;
    unique case (sfr_addr_i)
      REG_CTRL: sfr_rdata_o[1:0]      = {meen, pwe};
      REG_PAGE: sfr_rdata_o[PG_W-1:0] = page_field;
      REG_STAT: sfr_rdata_o[1:0]      = {hold, busy};
      default:  sfr_rdata_o           = '0;
    endcase
  end

  AST_START_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(erase_req_o) |-> $past(sfr_we_i && (sfr_addr_i == REG_CMD))) else $error("spurious start"); // R2

  AST_MASS_NEEDS_DBG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(erase_req_o) && erase_mass_o) |-> $past(dbg_en_i)) else $error("mass without debug"); // R3

  AST_ROUTE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mov_we_i |-> $onehot({prog_we_o, xram_we_o})) else $error("route not exclusive"); // R10
endmodule

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       gie = 1'b0, dbg = 1'b0, mov_we = 1'b0;
  logic [0:0] bank = 1'b0;
  logic       prog_we, xram_we, req, mass, ack;
  logic [6:0] page;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic       req_prev = 1'b0;
  int         stub_cnt = 0;
  logic       done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .sfr_we_i(we), .sfr_addr_i(addr),
    .sfr_wdata_i(wdata), .sfr_rdata_o(rdata), .gie_i(gie), .dbg_en_i(dbg),
    .bank_i(bank), .mov_we_i(mov_we), .prog_we_o(prog_we), .xram_we_o(xram_we),
    .erase_req_o(req), .erase_mass_o(mass), .erase_page_o(page), .erase_ack_i(ack)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // flash stub: acknowledge after a fixed delay
  initial ack = 1'b0;
  always @(negedge clk) begin
    ack <= 1'b0;
    if (!rst_n) stub_cnt <= 0;
    else if (req && !ack) begin
      if (stub_cnt == 2) begin ack <= 1'b1; stub_cnt <= 0; end
      else stub_cnt <= stub_cnt + 1;
    end
  end

  // monitor: each new request must match the head of the expected queue
  always @(negedge clk) begin
    if (req && !req_prev) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R5/R6/R7/R9: unexpected request actual %h expected none", {mass, page});
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if ({mass, page} !== e) begin
          errors++;
          $display("FAIL R2/R3: request actual %h expected %h", {mass, page}, e);
        end
      end
    end
    req_prev <= req;
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ack();
    while (req) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done_flag && cyc < WATCHDOG) begin @(posedge clk); cyc++; end
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle(2);
    // R1 reset state
    rd(2'd3, v); check("R1 status", v, 8'h00);
    rd(2'd1, v); check("R1 control", v, 8'h00);
    rd(2'd2, v); check("R1 page", v, 8'h00);
    check("R1 req", {7'd0, req}, 8'h00);
    rst_n = 1'b1;
    idle(1);

    // R2 page erase with bank bit
    bank = 1'b1;
    wr(2'd2, 8'h2A);
    exp_q.push_back({1'b0, 7'h6A});
    wr(2'd0, 8'h55);
    check("R2 req high", {7'd0, req}, 8'h01);
    rd(2'd3, v); check("R9 busy during req", v, 8'h01);
    wr(2'd0, 8'h55);                       // R9 ignored while busy
    wait_ack();
    rd(2'd3, v); check("R9 hold after ack", v, 8'h03);
    wr(2'd0, 8'hAA);                       // R9 nonzero does not close
    rd(2'd3, v); check("R9 still hold", v, 8'h03);
    wr(2'd0, 8'h00);
    rd(2'd3, v); check("R9 closed", v, 8'h00);

    // R5/R7 page mark consumed
    wr(2'd0, 8'h55);
    idle(2);
    rd(2'd3, v); check("R5 no rewrite ignored", v, 8'h00);

    // R4 stray key, page mark survives
    bank = 1'b0;
    wr(2'd2, 8'h05);
    wr(2'd0, 8'h33);
    idle(2);
    rd(2'd3, v); check("R4 stray key ignored", v, 8'h00);
    exp_q.push_back({1'b0, 7'h05});
    wr(2'd0, 8'h55);
    check("R4 valid after stray", {7'd0, req}, 8'h01);
    wait_ack();
    wr(2'd0, 8'h00);

    // R6 mass preconditions
    dbg = 1'b1;
    wr(2'd0, 8'hAA);
    idle(2);
    rd(2'd3, v); check("R6 no enable ignored", v, 8'h00);
    dbg = 1'b0;
    wr(2'd1, 8'h02);
    wr(2'd0, 8'hAA);
    idle(2);
    rd(2'd3, v); check("R6 no debug ignored", v, 8'h00);
    dbg = 1'b1;
    exp_q.push_back({1'b1, 7'h00});
    wr(2'd0, 8'hAA);
    check("R3 mass req", {6'd0, mass, req}, 8'h03);
    rd(2'd1, v); check("R7 enable cleared", v, 8'h00);
    // R9 close written during the request
    wr(2'd0, 8'h00);
    wait_ack();
    rd(2'd3, v); check("R9 early close", v, 8'h00);
    wr(2'd0, 8'hAA);
    idle(2);
    rd(2'd3, v); check("R7 mass needs rearm", v, 8'h00);

    // R10/R11 program write enable
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R10 pwe set", v, 8'h01);
    mov_we = 1'b1; #1;
    check("R10 prog route", {6'd0, prog_we, xram_we}, 8'h02);
    mov_we = 1'b0;
    gie = 1'b1;
    wr(2'd1, 8'h02);
    rd(2'd1, v); check("R11 pwe locked, enable written", v, 8'h03);
    gie = 1'b0;
    wr(2'd1, 8'h00);
    mov_we = 1'b1; #1;
    check("R10 xram route", {6'd0, prog_we, xram_we}, 8'h01);
    mov_we = 1'b0;

    // R12 reset aborts a request
    wr(2'd2, 8'h11);
    exp_q.push_back({1'b0, 7'h11});
    wr(2'd0, 8'h55);
    rst_n = 1'b0; #1;
    check("R12 req dropped", {7'd0, req}, 8'h00);
    rd(2'd3, v); check("R12 status cleared", v, 8'h00);
    idle(1);
    rst_n = 1'b1;
    idle(3);
    check("R2 scoreboard drained", 8'(exp_q.size()), 8'h00);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule